// File: doc/BRIEF.md
# Second-Chance Frame Replacement Engine

This block picks which physical frame receives a newly loaded page, using the clock (second-chance) policy over a ring of `NFRAMES` frames. Each frame carries one referenced bit. A hand pointer marks where the next search begins. A hit on a resident page sets that frame's bit. A replacement request then walks the ring from the hand, one frame per clock cycle. The walk clears every set bit it passes and stops at the first frame whose bit is already clear. That frame is reported as the victim, and the hand is left on the frame after it.

While some frames have never been filled, a request skips the walk and takes the lowest unfilled frame at once. Once every frame holds a page, the policy runs as described above. If every bit is set when a walk begins, the walk goes once around the ring, clearing each bit. It then stops on the frame it started from, which gives first-in-first-out order. The surrounding logic detects faults, moves page data and keeps the page-to-frame map. This block only chooses frames.

Top module: `clock_repl_engine`

## Requirements
- R1: After reset, `hand_o` is 0, every bit of `ref_bits_o` is 0, no frame counts as filled, and `done_o` and `busy_o` are low.
- R2: While unfilled frames remain, a request on `repl_req_i` takes frame number k, where k is the number of frames filled so far. `done_o` pulses in the cycle after the request, with `victim_o` = k and `hand_o` = (k+1) mod NFRAMES.
- R3: A hit pulse on `hit_valid_i` with a filled frame index on `hit_frame_i` sets `ref_bits_o[hit_frame_i]` (bit i belongs to frame i) and leaves `hand_o` unchanged. A hit on an unfilled frame, or on an index of NFRAMES or above, changes nothing.
- R4: When all frames are filled, a search starts at the frame under the hand and examines one frame per cycle. A frame whose bit is set has that bit cleared and is passed, and the hand moves on by one, wrapping from NFRAMES-1 to 0.
- R5: The first examined frame with a clear bit is the victim. `done_o` is high for one cycle, with `victim_o` holding its index. `busy_o` is high in each cycle of a search that is still running, and low when `done_o` is high.
- R6: At `done_o`, `hand_o` = (`victim_o`+1) mod NFRAMES and the victim's referenced bit is clear.
- R7: If every bit is set when a search starts, the victim is the starting frame and every bit ends clear. `done_o` arrives no later than NFRAMES+1 cycles after the request.
- R8: A request raised while `busy_o` is high is ignored: no extra search and no extra `done_o` follows.
- R9: For the reference string A B C D A B E A B C D E, starting from reset, the number of requests needed is 8 with four frames and 10 with three frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| hit_valid_i | input | 1 | One-cycle pulse: the page in `hit_frame_i` was referenced |
| hit_frame_i | input | IDX_W | Frame index of the referenced page |
| repl_req_i | input | 1 | Request a frame for a new page |
| busy_o | output | 1 | A multi-cycle search is running |
| done_o | output | 1 | One-cycle pulse: `victim_o` is valid |
| victim_o | output | IDX_W | Frame chosen for the new page |
| hand_o | output | IDX_W | Frame where the next search starts |
| ref_bits_o | output | NFRAMES | Referenced bit of each frame |

## Verification
A wrong hand or a stale referenced bit shows at the ports only when a later request is served. The victim index, the hand position after `done_o`, or the search length then differs from the policy. An error can therefore stay hidden through many hits and appear several requests later. For this reason the bench replays whole reference strings and compares every victim, every hand position and the total number of requests. A bit-clearing fault shows more quickly: `ref_bits_o` differs in the cycle after the faulty examination. An unbounded walk is caught within NFRAMES+1 cycles by the search-length limit.

// File: rtl/clock_repl_pkg.sv
package clock_repl_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

endpackage

// File: rtl/clock_idx_wrap.sv
// Ring successor: next frame index, wrapping at the last frame.
module clock_idx_wrap #(
    parameter int unsigned NFRAMES = 4,
    parameter int unsigned IDX_W   = 2
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] nxt_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NFRAMES - 1);

    always_comb begin
        if (idx_i == LAST) begin
            nxt_o = '0;
        end else begin
            nxt_o = idx_i + 1'b1;
        end
    end
endmodule

// File: rtl/clock_hit_decode.sv
// Turns a hit pulse into a per-frame set mask; frames not yet filled are masked off.
module clock_hit_decode #(
    parameter int unsigned NFRAMES = 4,
    parameter int unsigned IDX_W   = 2,
    parameter int unsigned CNT_W   = 3
) (
    input  logic               valid_i,
    input  logic [IDX_W-1:0]   frame_i,
    input  logic [CNT_W-1:0]   filled_i,
    output logic [NFRAMES-1:0] set_o
);
    for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
        assign set_o[g] = valid_i
                        && (frame_i == IDX_W'(g))
                        && (CNT_W'(g) < filled_i);
    end
endmodule

// File: rtl/clock_repl_engine.sv
module clock_repl_engine
    import clock_repl_pkg::*;
#(
    parameter int unsigned NFRAMES = 4,
    parameter int unsigned IDX_W   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               hit_valid_i,
    input  logic [IDX_W-1:0]   hit_frame_i,
    input  logic               repl_req_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [IDX_W-1:0]   victim_o,
    output logic [IDX_W-1:0]   hand_o,
    output logic [NFRAMES-1:0] ref_bits_o
);
    localparam int unsigned       CNT_W  = $clog2(NFRAMES + 1);
    localparam logic [CNT_W-1:0]  ALL_IN = CNT_W'(NFRAMES);

    typedef struct packed {
        scan_state_e        st;
        logic [NFRAMES-1:0] refb;
        logic [IDX_W-1:0]   hand;
        logic [CNT_W-1:0]   filled;
        logic               done;
        logic [IDX_W-1:0]   victim;
    } eng_state_t;

    eng_state_t state_d, state_q;

    logic [NFRAMES-1:0] set_mask;
    logic [IDX_W-1:0]   hand_succ;
    logic [IDX_W-1:0]   fill_idx;
    logic [IDX_W-1:0]   fill_succ;
    logic               ring_full;
    logic               take_empty;
    logic               examine;

    assign fill_idx = state_q.filled[IDX_W-1:0];

    clock_hit_decode #(
        .NFRAMES (NFRAMES),
        .IDX_W   (IDX_W),
        .CNT_W   (CNT_W)
    ) u_hit (
        .valid_i  (hit_valid_i),
        .frame_i  (hit_frame_i),
        .filled_i (state_q.filled),
        .set_o    (set_mask)
    );

    clock_idx_wrap #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_hand_wrap (
        .idx_i (state_q.hand),
        .nxt_o (hand_succ)
    );

    clock_idx_wrap #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_fill_wrap (
        .idx_i (fill_idx),
        .nxt_o (fill_succ)
    );

    always_comb begin
        ring_full  = (state_q.filled == ALL_IN);
        take_empty = (state_q.st == ST_IDLE) && repl_req_i && !ring_full;
        examine    = (state_q.st == ST_SCAN)
                   || ((state_q.st == ST_IDLE) && repl_req_i && ring_full);

        state_d      = state_q;
        state_d.done = 1'b0;
        state_d.refb = state_q.refb | set_mask;

        if (take_empty) begin
            // Fill in index order; a fresh page starts with its bit clear.
            state_d.victim         = fill_idx;
            state_d.done           = 1'b1;
            state_d.filled         = state_q.filled + 1'b1;
            state_d.hand           = fill_succ;
            state_d.refb[fill_idx] = 1'b0;
        end else if (examine) begin
            state_d.hand = hand_succ;
            if (state_q.refb[state_q.hand]) begin
                // Second chance: clear and move on; a same-cycle hit keeps it set.
                state_d.refb[state_q.hand] = set_mask[state_q.hand];
                state_d.st                 = ST_SCAN;
            end else begin
                state_d.refb[state_q.hand] = 1'b0;
                state_d.victim             = state_q.hand;
                state_d.done               = 1'b1;
                state_d.st                 = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '{st: ST_IDLE, refb: '0, hand: '0, filled: '0,
                         done: 1'b0, victim: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o     = (state_q.st == ST_SCAN);
    assign done_o     = state_q.done;
    assign victim_o   = state_q.victim;
    assign hand_o     = state_q.hand;
    assign ref_bits_o = state_q.refb;
endmodule

// File: rtl/clock_repl_checker.sv
module clock_repl_checker #(
    parameter int unsigned NFRAMES = 4,
    parameter int unsigned IDX_W   = 2
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               repl_req_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [IDX_W-1:0]   victim_o,
    input logic [IDX_W-1:0]   hand_o,
    input logic [NFRAMES-1:0] ref_bits_o
);
    int unsigned busy_run;

    always_ff @(posedge clk_i) begin
        if (!rst_ni || !busy_o) begin
            busy_run <= 0;
        end else begin
            busy_run <= busy_run + 1;
        end
    end

    // R6: hand sits one past the victim when the result is reported
    a_r6_hand_past_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (int'(hand_o) == ((int'(victim_o) + 1) % NFRAMES)));

    // R6: the victim frame holds a new page with a clear bit
    a_r6_victim_bit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !ref_bits_o[victim_o]);

    // R4: each cycle of a running search moves the hand exactly one frame
    a_r4_hand_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(busy_o) |-> (int'(hand_o) == ((int'($past(hand_o)) + 1) % NFRAMES)));

    // R3: with no request and no search the hand does not move
    a_r3_hand_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(busy_o) && !$past(repl_req_i)) |-> $stable(hand_o));

    // R5: a finished search is no longer busy
    a_r5_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R7: a search never stays busy longer than one trip round the ring
    a_r7_bounded_search: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_run <= NFRAMES);
endmodule

bind clock_repl_engine clock_repl_checker #(
    .NFRAMES (NFRAMES),
    .IDX_W   (IDX_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .repl_req_i (repl_req_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .victim_o   (victim_o),
    .hand_o     (hand_o),
    .ref_bits_o (ref_bits_o)
);

// File: tb/clock_repl_engine_tb.sv
module clock_repl_engine_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    // Shared stimulus, steered to one of two instances by sel.
    int         sel = 4;
    logic       hv = 1'b0;
    logic [1:0] hf = '0;
    logic       rq = 1'b0;

    logic       a_busy, a_done, b_busy, b_done;
    logic [1:0] a_vic, a_hand, b_vic, b_hand;
    logic [3:0] a_bits;
    logic [2:0] b_bits;

    clock_repl_engine #(.NFRAMES(4)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .hit_valid_i(hv && sel == 4), .hit_frame_i(hf), .repl_req_i(rq && sel == 4),
        .busy_o(a_busy), .done_o(a_done), .victim_o(a_vic), .hand_o(a_hand),
        .ref_bits_o(a_bits));

    clock_repl_engine #(.NFRAMES(3)) u_dut3 (
        .clk_i(clk), .rst_ni(rst_n),
        .hit_valid_i(hv && sel == 3), .hit_frame_i(hf), .repl_req_i(rq && sel == 3),
        .busy_o(b_busy), .done_o(b_done), .victim_o(b_vic), .hand_o(b_hand),
        .ref_bits_o(b_bits));

    logic       c_busy, c_done;
    logic [1:0] c_vic, c_hand;
    logic [3:0] c_bits;
    assign c_busy = (sel == 4) ? a_busy : b_busy;
    assign c_done = (sel == 4) ? a_done : b_done;
    assign c_vic  = (sel == 4) ? a_vic  : b_vic;
    assign c_hand = (sel == 4) ? a_hand : b_hand;
    assign c_bits = (sel == 4) ? a_bits : {1'b0, b_bits};

    // Vector: {page[3:0], is_hit, victim[1:0], hand_after[1:0]}; pages A..E = 0..4.
    localparam logic [8:0] TAB4 [12] = '{
        {4'd0,1'b0,2'd0,2'd1}, {4'd1,1'b0,2'd1,2'd2}, {4'd2,1'b0,2'd2,2'd3},
        {4'd3,1'b0,2'd3,2'd0}, {4'd0,1'b1,2'd0,2'd0}, {4'd1,1'b1,2'd0,2'd0},
        {4'd4,1'b0,2'd2,2'd3}, {4'd0,1'b1,2'd0,2'd3}, {4'd1,1'b1,2'd0,2'd3},
        {4'd2,1'b0,2'd3,2'd0}, {4'd3,1'b0,2'd2,2'd3}, {4'd4,1'b0,2'd3,2'd0}};
    localparam logic [8:0] TAB3 [12] = '{
        {4'd0,1'b0,2'd0,2'd1}, {4'd1,1'b0,2'd1,2'd2}, {4'd2,1'b0,2'd2,2'd0},
        {4'd3,1'b0,2'd0,2'd1}, {4'd0,1'b0,2'd1,2'd2}, {4'd1,1'b0,2'd2,2'd0},
        {4'd4,1'b0,2'd0,2'd1}, {4'd0,1'b1,2'd0,2'd1}, {4'd1,1'b1,2'd0,2'd1},
        {4'd2,1'b0,2'd0,2'd1}, {4'd3,1'b0,2'd1,2'd2}, {4'd4,1'b0,2'd2,2'd0}};

    int n_chk = 0;
    int n_bad = 0;
    int faults = 0;
    int frame_of [5];
    bit ended = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Request a frame and wait for the result; returns cycles until done.
    task automatic request(output int cycles);
        rq = 1'b1;
        @(negedge clk);
        rq = 1'b0;
        cycles = 1;
        while (!c_done && cycles <= sel + 1) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic access(input logic [8:0] e);
        int pg, vic, hnd, f, cyc;
        pg  = int'(e[8:5]);
        vic = int'(e[3:2]);
        hnd = int'(e[1:0]);
        if (e[4]) begin
            f = frame_of[pg];
            check(f >= 0, "R9 page resident", f, 0);
            if (f < 0) f = 0;
            hv = 1'b1;
            hf = 2'(f);
            @(negedge clk);
            hv = 1'b0;
            check(c_bits[f] == 1'b1, "R3 hit sets bit", int'(c_bits[f]), 1);
            check(int'(c_hand) == hnd, "R3 hit keeps hand", int'(c_hand), hnd);
        end else begin
            faults++;
            request(cyc);
            check(c_done == 1'b1, "R5 done pulse", int'(c_done), 1);
            check(cyc <= sel + 1, "R7 search length", cyc, sel + 1);
            check(int'(c_vic) == vic, "R5 victim", int'(c_vic), vic);
            check(int'(c_hand) == hnd, "R6 hand after", int'(c_hand), hnd);
            check(c_bits[vic] == 1'b0, "R6 victim bit", int'(c_bits[vic]), 0);
            for (int p = 0; p < 5; p++) if (frame_of[p] == vic) frame_of[p] = -1;
            frame_of[pg] = vic;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int cyc;
        logic [2:0] keep3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(a_hand == 2'd0 && a_bits == 4'd0, "R1 hand/bits", int'({a_hand, a_bits}), 0);
        check(!a_done && !a_busy, "R1 done/busy", int'({a_done, a_busy}), 0);

        // R3 hit on an unfilled frame is ignored
        sel = 4; hv = 1'b1; hf = 2'd2;
        @(negedge clk);
        hv = 1'b0;
        check(a_bits == 4'd0, "R3 unfilled hit ignored", int'(a_bits), 0);

        // R2/R4..R6/R9: reference strings through the table
        for (int p = 0; p < 5; p++) frame_of[p] = -1;
        faults = 0;
        for (int i = 0; i < 12; i++) begin
            access(TAB4[i]);
            if (i < 4) check(int'(a_vic) == i, "R2 fill order", int'(a_vic), i);
        end
        check(faults == 8, "R9 four-frame requests", faults, 8);

        sel = 3;
        for (int p = 0; p < 5; p++) frame_of[p] = -1;
        faults = 0;
        for (int i = 0; i < 12; i++) access(TAB3[i]);
        check(faults == 10, "R9 three-frame requests", faults, 10);

        // R3: index beyond the ring is ignored
        keep3 = b_bits;
        hv = 1'b1; hf = 2'd3;
        @(negedge clk);
        hv = 1'b0;
        check(b_bits == keep3, "R3 out-of-range hit ignored", int'(b_bits), int'(keep3));
        check(b_hand == 2'd0, "R3 out-of-range hand", int'(b_hand), 0);

        // R7/R8: all bits set, extra requests during the search
        sel = 4;
        for (int f = 0; f < 4; f++) begin
            hv = 1'b1; hf = 2'(f);
            @(negedge clk);
        end
        hv = 1'b0;
        check(a_bits == 4'hF, "R3 all bits set", int'(a_bits), 15);
        rq = 1'b1;
        @(negedge clk);
        check(a_busy == 1'b1, "R5 busy during search", int'(a_busy), 1);
        @(negedge clk);
        @(negedge clk);
        rq = 1'b0;
        cyc = 3;
        while (!a_done && cyc <= 6) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == 5, "R7 full circle length", cyc, 5);
        check(a_vic == 2'd0, "R7 victim is start", int'(a_vic), 0);
        check(a_hand == 2'd1, "R7 hand after", int'(a_hand), 1);
        check(a_bits == 4'd0, "R7 bits cleared", int'(a_bits), 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!a_done && !a_busy, "R8 busy request ignored", int'({a_done, a_busy}), 0);
        end

        // R1/R2: reset mid-run, then immediate fill of frame 0
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(a_hand == 2'd0 && a_bits == 4'd0, "R1 reset again", int'({a_hand, a_bits}), 0);
        request(cyc);
        check(cyc == 1 && a_vic == 2'd0, "R2 fill after reset", int'(a_vic) + 10 * cyc, 10);
        check(a_hand == 2'd1, "R2 hand after fill", int'(a_hand), 1);

        finish_run();
    end
endmodule